// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the two error counters of a CAN node and derives its fault-confinement state. The protocol engine sends it single-cycle strobes for a failed or a completed transmission and for a failed or a completed reception. The block adds to or subtracts from the transmit error count (TEC) or the receive error count (REC) according to these strobes. From the counts it sets exactly one of three flags: error-active, error-passive or bus-off.

The frame logic reads the flags. An error-active node signals errors with active error flags. An error-passive node may only send passive error flags. A bus-off node must keep off the bus completely. While the node is bus-off, the block watches the sampled bus bits for recessive runs. After enough complete runs it returns the node to error-active with both counts cleared.

Every output is registered. An event strobe seen at a rising edge shows in the counts and flags right after that edge.

Top module: `canFaultConf`

## Requirements
- R1: After reset the node is error-active and both TEC and REC read 0.
- R2: A transmit error strobe adds 8 to TEC and a receive error strobe adds 1 to REC. An error strobe wins over a success strobe of the same direction in the same cycle.
- R3: A success strobe with no error strobe of the same direction lowers the matching counter by 1. A counter already at 0 stays at 0.
- R4: When not bus-off, the node is error-passive whenever TEC or REC is above 127.
- R5: The node becomes bus-off in the cycle TEC rises above 255. While bus-off, all four event strobes are ignored and both counters hold their values.
- R6: When not bus-off, the node is error-active whenever TEC and REC are both at or below 127.
- R7: While bus-off, each cycle with `bitTick` high counts one sampled bit, and `rxBit` = 1 means recessive. Eleven recessive bits in a row make one completed run. A dominant bit restarts the current run but keeps the runs already completed. When the 128th run completes, TEC and REC become 0 and the node becomes error-active at the same edge.
- R8: REC saturates at 255 instead of wrapping.
- R9: Exactly one of the three state flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txErrStb | input | 1 | Error detected while transmitting |
| txOkStb | input | 1 | Frame transmitted successfully |
| rxErrStb | input | 1 | Error detected while receiving |
| rxOkStb | input | 1 | Frame received successfully |
| bitTick | input | 1 | One sampled bus bit is valid this cycle |
| rxBit | input | 1 | Sampled bus level, 1 = recessive |
| errActive | output | 1 | Node is error-active |
| errPassive | output | 1 | Node is error-passive |
| busOff | output | 1 | Node is bus-off |
| tecVal | output | 9 | Transmit error count |
| recVal | output | 8 | Receive error count |

## Verification
The assertions assume that each event strobe is a one-cycle pulse that the engine raises at most once per frame event. Any mix of the four strobes in one cycle is legal. They also assume that `bitTick` pulses once per sampled bit and that `rxBit` is meaningful only when `bitTick` is high. The bench drives every strobe pattern, including simultaneous opposite-direction events and error-plus-success pairs. Its random phase biases transmit errors upward so that bus-off is reached. It then keeps recessive bits frequent, with rare dominant bits, so that recovery completes within the run.

// File: rtl/canFcPkg.sv
package canFcPkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fcState_t;

  // strobes from the control to the counter datapath
  typedef struct packed {
    logic tecInc;
    logic tecDec;
    logic recInc;
    logic recDec;
    logic clearAll;
  } cntCmd_t;

endpackage

// File: rtl/canFcCounters.sv
module canFcCounters
  import canFcPkg::*;
#(
  parameter int TEC_W   = 9,
  parameter int REC_W   = 8,
  parameter int TX_STEP = 8,
  parameter int RX_STEP = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  output logic [TEC_W-1:0] tecQ,
  output logic [REC_W-1:0] recQ,
  output logic [TEC_W-1:0] tecNxt,
  output logic [REC_W-1:0] recNxt
);

  localparam logic [REC_W:0]   REC_SAT = {1'b0, {REC_W{1'b1}}};
  localparam logic [REC_W:0]   REC_INC = (REC_W+1)'(RX_STEP);
  localparam logic [TEC_W-1:0] TEC_INC = TEC_W'(TX_STEP);

  logic [REC_W:0] recSum;

  always_comb begin
    recSum = {1'b0, recQ} + REC_INC;

    tecNxt = tecQ;
    if (cmd.clearAll)                      tecNxt = '0;
    else if (cmd.tecInc)                   tecNxt = tecQ + TEC_INC;
    else if (cmd.tecDec && (tecQ != '0))   tecNxt = tecQ - 1'b1;

    recNxt = recQ;
    if (cmd.clearAll)                      recNxt = '0;
    else if (cmd.recInc)                   recNxt = (recSum > REC_SAT) ? REC_SAT[REC_W-1:0]
                                                                       : recSum[REC_W-1:0];
    else if (cmd.recDec && (recQ != '0))   recNxt = recQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tecQ <= '0;
      recQ <= '0;
    end else begin
      tecQ <= tecNxt;
      recQ <= recNxt;
    end
  end

endmodule

// File: rtl/canFcRecovery.sv
module canFcRecovery #(
  parameter int RUN_BITS  = 11,
  parameter int RUN_TOTAL = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic bitTick,
  input  logic rxBit,
  output logic done
);

  localparam int RUN_W = $clog2(RUN_BITS);
  localparam int OCC_W = $clog2(RUN_TOTAL);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_BITS - 1);
  localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(RUN_TOTAL - 1);

  logic [RUN_W-1:0] runCnt;
  logic [OCC_W-1:0] occCnt;
  logic             runEnd;

  always_comb begin
    runEnd = enable && bitTick && rxBit && (runCnt == RUN_LAST);
    done   = runEnd && (occCnt == OCC_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      runCnt <= '0;
      occCnt <= '0;
    end else if (bitTick) begin
      if (!rxBit) begin
        runCnt <= '0;
      end else if (runEnd) begin
        runCnt <= '0;
        occCnt <= occCnt + 1'b1;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/canFcControl.sv
module canFcControl
  import canFcPkg::*;
#(
  parameter int TEC_W         = 9,
  parameter int REC_W         = 8,
  parameter int PASSIVE_LIMIT = 127,
  parameter int BUSOFF_LIMIT  = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErrStb,
  input  logic             txOkStb,
  input  logic             rxErrStb,
  input  logic             rxOkStb,
  input  logic             recovDone,
  input  logic [TEC_W-1:0] tecNxt,
  input  logic [REC_W-1:0] recNxt,
  output cntCmd_t          cmd,
  output logic             inBusOff,
  output logic             errActive,
  output logic             errPassive,
  output logic             busOff
);

  localparam logic [TEC_W-1:0] TEC_PAS = TEC_W'(PASSIVE_LIMIT);
  localparam logic [REC_W-1:0] REC_PAS = REC_W'(PASSIVE_LIMIT);
  localparam logic [TEC_W-1:0] TEC_OFF = TEC_W'(BUSOFF_LIMIT);

  fcState_t stateQ, stateNxt;

  always_comb begin
    inBusOff     = (stateQ == FC_BUSOFF);
    cmd.tecInc   = !inBusOff && txErrStb;
    cmd.tecDec   = !inBusOff && !txErrStb && txOkStb;
    cmd.recInc   = !inBusOff && rxErrStb;
    cmd.recDec   = !inBusOff && !rxErrStb && rxOkStb;
    cmd.clearAll = inBusOff && recovDone;

    if (inBusOff)
      stateNxt = recovDone ? FC_ACTIVE : FC_BUSOFF;
    else if (tecNxt > TEC_OFF)
      stateNxt = FC_BUSOFF;
    else if ((tecNxt > TEC_PAS) || (recNxt > REC_PAS))
      stateNxt = FC_PASSIVE;
    else
      stateNxt = FC_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= FC_ACTIVE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    errActive  = (stateQ == FC_ACTIVE);
    errPassive = (stateQ == FC_PASSIVE);
    busOff     = (stateQ == FC_BUSOFF);
  end

endmodule

// File: rtl/canFaultConf.sv
module canFaultConf
  import canFcPkg::*;
#(
  parameter int TEC_W         = 9,
  parameter int REC_W         = 8,
  parameter int TX_STEP       = 8,
  parameter int RX_STEP       = 1,
  parameter int PASSIVE_LIMIT = 127,
  parameter int BUSOFF_LIMIT  = 255,
  parameter int RUN_BITS      = 11,
  parameter int RUN_TOTAL     = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErrStb,
  input  logic             txOkStb,
  input  logic             rxErrStb,
  input  logic             rxOkStb,
  input  logic             bitTick,
  input  logic             rxBit,
  output logic             errActive,
  output logic             errPassive,
  output logic             busOff,
  output logic [TEC_W-1:0] tecVal,
  output logic [REC_W-1:0] recVal
);

  cntCmd_t          cmd;
  logic [TEC_W-1:0] tecNxt;
  logic [REC_W-1:0] recNxt;
  logic             recovDone;
  logic             inBusOff;

  canFcControl #(
    .TEC_W(TEC_W), .REC_W(REC_W),
    .PASSIVE_LIMIT(PASSIVE_LIMIT), .BUSOFF_LIMIT(BUSOFF_LIMIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .txErrStb(txErrStb), .txOkStb(txOkStb),
    .rxErrStb(rxErrStb), .rxOkStb(rxOkStb),
    .recovDone(recovDone), .tecNxt(tecNxt), .recNxt(recNxt),
    .cmd(cmd), .inBusOff(inBusOff),
    .errActive(errActive), .errPassive(errPassive), .busOff(busOff)
  );

  canFcCounters #(
    .TEC_W(TEC_W), .REC_W(REC_W), .TX_STEP(TX_STEP), .RX_STEP(RX_STEP)
  ) cnt_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .tecQ(tecVal), .recQ(recVal), .tecNxt(tecNxt), .recNxt(recNxt)
  );

  canFcRecovery #(
    .RUN_BITS(RUN_BITS), .RUN_TOTAL(RUN_TOTAL)
  ) rec_i (
    .clk(clk), .rstN(rstN), .enable(inBusOff),
    .bitTick(bitTick), .rxBit(rxBit), .done(recovDone)
  );

endmodule

// File: rtl/canFcChecker.sv
module canFcChecker #(
  parameter int TEC_W         = 9,
  parameter int REC_W         = 8,
  parameter int TX_STEP       = 8,
  parameter int PASSIVE_LIMIT = 127,
  parameter int BUSOFF_LIMIT  = 255
) (
  input logic             clk,
  input logic             rstN,
  input logic             txErrStb,
  input logic             txOkStb,
  input logic             rxErrStb,
  input logic             errActive,
  input logic             errPassive,
  input logic             busOff,
  input logic [TEC_W-1:0] tecVal,
  input logic [REC_W-1:0] recVal
);

  localparam logic [TEC_W-1:0] TEC_PAS = TEC_W'(PASSIVE_LIMIT);
  localparam logic [REC_W-1:0] REC_PAS = REC_W'(PASSIVE_LIMIT);
  localparam logic [TEC_W-1:0] TEC_OFF = TEC_W'(BUSOFF_LIMIT);
  localparam logic [TEC_W-1:0] TEC_INC = TEC_W'(TX_STEP);
  localparam logic [REC_W-1:0] REC_ALL = {REC_W{1'b1}};

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({errActive, errPassive, busOff})); // R9

  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && txErrStb) |=> (tecVal == $past(tecVal) + TEC_INC)); // R2

  AST_TEC_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && txOkStb && !txErrStb && tecVal == '0) |=> (tecVal == '0)); // R3

  AST_PASSIVE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && (tecVal > TEC_PAS || recVal > REC_PAS)) |-> errPassive); // R4

  AST_OFF_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (tecVal > TEC_OFF) |-> busOff); // R5

  AST_ACTIVE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && tecVal <= TEC_PAS && recVal <= REC_PAS) |-> errActive); // R6

  // frozen counts while locked out (R5), or a clean exit
  AST_OFF_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    busOff |=> ((busOff && $stable(tecVal) && $stable(recVal)) ||
                (errActive && tecVal == '0 && recVal == '0))); // R7

  AST_REC_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && rxErrStb && recVal == REC_ALL) |=> (recVal == REC_ALL)); // R8

endmodule

bind canFaultConf canFcChecker #(
  .TEC_W(TEC_W), .REC_W(REC_W), .TX_STEP(TX_STEP),
  .PASSIVE_LIMIT(PASSIVE_LIMIT), .BUSOFF_LIMIT(BUSOFF_LIMIT)
) chk_i (
  .clk(clk), .rstN(rstN), .txErrStb(txErrStb), .txOkStb(txOkStb),
  .rxErrStb(rxErrStb), .errActive(errActive), .errPassive(errPassive),
  .busOff(busOff), .tecVal(tecVal), .recVal(recVal)
);

// File: tb/canFaultConf_tb_top.sv
`timescale 1ns/1ps
module canFaultConf_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txErrStb = 1'b0, txOkStb = 1'b0, rxErrStb = 1'b0, rxOkStb = 1'b0;
  logic       bitTick = 1'b0, rxBit = 1'b1;
  logic       errActive, errPassive, busOff;
  logic [8:0] tecVal;
  logic [7:0] recVal;

  int checks = 0;
  int errors = 0;
  // reference state: 0 active, 1 passive, 2 bus-off
  int mTec = 0, mRec = 0, mSt = 0, mRun = 0, mOcc = 0;

  always #2 clk = ~clk;

  canFaultConf dut_i (
    .clk(clk), .rstN(rstN),
    .txErrStb(txErrStb), .txOkStb(txOkStb),
    .rxErrStb(rxErrStb), .rxOkStb(rxOkStb),
    .bitTick(bitTick), .rxBit(rxBit),
    .errActive(errActive), .errPassive(errPassive), .busOff(busOff),
    .tecVal(tecVal), .recVal(recVal)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int stCode();
    return busOff ? 2 : (errPassive ? 1 : 0);
  endfunction

  task automatic chkAll(input string tag);
    chk(tag, "tec", int'(tecVal), mTec);
    chk(tag, "rec", int'(recVal), mRec);
    chk(tag, "state", stCode(), mSt);
    chk("R9", "flag count", int'(errActive) + int'(errPassive) + int'(busOff), 1);
  endtask

  function automatic void modelStep(bit te, bit to, bit re, bit ro, bit tk, bit bt);
    if (mSt != 2) begin
      if (te) mTec += 8; else if (to && mTec > 0) mTec--;
      if (re) mRec = (mRec + 1 > 255) ? 255 : mRec + 1;
      else if (ro && mRec > 0) mRec--;
      if (mTec > 255) mSt = 2;
      else if (mTec > 127 || mRec > 127) mSt = 1;
      else mSt = 0;
      mRun = 0; mOcc = 0;
    end else if (tk) begin
      if (!bt) mRun = 0;
      else if (mRun == 10) begin
        mRun = 0;
        if (mOcc == 127) begin mTec = 0; mRec = 0; mSt = 0; mOcc = 0; end
        else mOcc++;
      end else mRun++;
    end
  endfunction

  task automatic step(input bit te, to, re, ro, tk, bt, input string tag, input bit doChk = 1'b1);
    @(negedge clk);
    txErrStb = te; txOkStb = to; rxErrStb = re; rxOkStb = ro; bitTick = tk; rxBit = bt;
    modelStep(te, to, re, ro, tk, bt);
    @(posedge clk); #1;
    if (doChk) chkAll(tag);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chkAll("R1");
    chk("R1", "active flag", int'(errActive), 1);

    step(0,1,0,1,0,1, "R3");                 // floor at zero
    step(0,0,1,0,0,1, "R2");
    step(0,0,1,0,0,1, "R2");
    step(0,0,1,1,0,1, "R2");                 // error beats success
    step(1,1,0,0,0,1, "R2");                 // tec 8
    step(0,1,0,0,0,1, "R3");                 // tec 7
    step(0,0,0,1,0,1, "R3");                 // rec 2
    for (int i = 0; i < 300; i++) step(0,0,1,0,0,1, "R8");
    chk("R8", "rec saturated", int'(recVal), 255);
    chk("R4", "passive flag", int'(errPassive), 1);
    for (int i = 0; i < 128; i++) step(0,0,0,1,0,1, "R6");
    chk("R6", "active at 127", int'(errActive), 1);
    step(0,0,1,0,0,1, "R4");                 // rec 128 -> passive
    step(0,0,0,1,0,1, "R6");
    for (int i = 0; i < 32; i++) step(1,0,0,0,0,1, "R5");
    chk("R5", "busoff flag", int'(busOff), 1);
    chk("R5", "tec value", int'(tecVal), 263);
    step(1,1,1,1,0,1, "R5");                 // all strobes ignored
    step(0,1,0,1,0,1, "R5");
    for (int i = 0; i < 10; i++) step(0,0,0,0,1,1, "R7", 1'b0);
    step(0,0,0,0,1,0, "R7");                 // dominant bit restarts run
    for (int i = 0; i < 1407; i++) step(0,0,0,0,(i % 5) != 0 || 1'b1, 1, "R7", 1'b0);
    step(0,0,0,0,0,1, "R7");                 // no tick: nothing counts
    chk("R7", "still busoff", int'(busOff), 1);
    step(0,0,0,0,1,1, "R7");
    chk("R7", "recovered active", int'(errActive), 1);
    chk("R7", "tec cleared", int'(tecVal), 0);

    for (int i = 0; i < 6000; i++) begin
      step(($urandom % 10) == 0, ($urandom % 10) < 3,
           ($urandom % 5) == 0, ($urandom % 5) < 2,
           ($urandom % 4) != 0, ($urandom % 64) != 0, "R9");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule